// File: doc/BRIEF.md
# Operand Address and Access Exception Checker

This block sits in front of the execute stage of a logical-instruction pipeline. For each operand it adds the index-register contents, the base-register contents and the displacement, modulo 2^24, to form the effective address. It reads both registers through a two-port general-register read interface. A register field of zero stands for a zero component, not for register 0.

In the same cycle the block checks the access for three kinds of fault: a misaligned full-word operand or an odd first register of a pair, an address beyond installed memory, and a storage-key mismatch. It reports at most one fault, chosen by priority. It also says whether the instruction must be suppressed or terminated. That choice depends on the kind of fault and on whether the instruction is a storage-to-storage variable-length operation.

Results are registered. The address and the verdict appear together one cycle after the request, before any part of the instruction executes.

Top module: `opnd_access_check`

## Requirements
- R1: One cycle after a cycle with `chkValid`=1, `effAddr` equals (index component + base component + zero-extended `disp`) modulo 2^24. Each component is the low 24 bits of the register that its field names.
- R2: A value of 0 in `idxSel` or `baseSel` makes that component zero, whatever the register read port returns for register 0.
- R3: `resValid` is 1 exactly in the cycle after a cycle with `chkValid`=1. While `resValid` is 0, `excCode`=0, `suppress`=0 and `terminate`=0.
- R4: A specification fault sets `excCode`=1 with `suppress`=1 and `terminate`=0. The fault exists when `isVarLen`=0 (full-word operand) and the two low address bits are not 00, or when `pairOp`=1 and bit 0 of `firstReg` is 1.
- R5: An addressing fault sets `excCode`=2 with `terminate`=1 and `suppress`=0. The fault exists when the first byte or the last byte is at or above `memSize`. The last byte is at address + `lenM1` when `isVarLen`=1, and at address + 3 otherwise, both modulo 2^24. A last byte at exactly `memSize`-1 is not a fault.
- R6: A protection fault sets `excCode`=3. It exists when `protectEn`=1, `progKey`≠0 and `storKey`≠`progKey`. With `ssVarLen`=0 it gives `suppress`=1, `terminate`=0. With `ssVarLen`=1 it gives `terminate`=1, `suppress`=0.
- R7: When several faults exist, only one is reported. Specification wins over addressing, and addressing wins over protection.
- R8: With no fault, `excCode`=0 and both `suppress` and `terminate` are 0.
- R9: While `rstN` is 0, `resValid`, `excCode`, `suppress`, `terminate` and `effAddr` are all 0.
- R10: With `protectEn`=0, or with `progKey`=0, no protection fault is reported for any key pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chkValid | input | 1 | Request: the operand fields below are valid |
| idxSel | input | 4 | Index register number, 0 = none |
| baseSel | input | 4 | Base register number, 0 = none |
| disp | input | 12 | Displacement |
| gprAddrIdx | output | 4 | Register read address for the index component |
| gprDataIdx | input | 32 | Register read data for the index component |
| gprAddrBase | output | 4 | Register read address for the base component |
| gprDataBase | input | 32 | Register read data for the base component |
| lenM1 | input | 8 | Variable-length operand byte count minus one |
| isVarLen | input | 1 | 1 = variable-length operand, 0 = full-word operand |
| pairOp | input | 1 | Instruction works on an even/odd register pair |
| firstReg | input | 4 | First register number of the instruction |
| memSize | input | 25 | Installed memory size in bytes |
| storKey | input | 4 | Storage key of the target location |
| progKey | input | 4 | Protection key of the program |
| protectEn | input | 1 | Memory protection installed and active |
| ssVarLen | input | 1 | Storage-to-storage variable-length instruction |
| resValid | output | 1 | Result valid |
| effAddr | output | 24 | Effective address |
| excCode | output | 2 | 0 none, 1 specification, 2 addressing, 3 protection |
| suppress | output | 1 | Operation must be suppressed |
| terminate | output | 1 | Operation must be terminated |

## Verification
The assertions check several rules on every cycle:
- the result follows the request by one cycle;
- outputs are quiet between results;
- the action is fixed for each specification and addressing fault;
- suppress and terminate are never raised together;
- an odd pair register always wins;
- zero register fields yield the bare displacement;
- a disabled protection check never reports a key fault.

Only the bench's behavioural model, compared on every clock, can show the rest: the exact address sums, including wrap past 2^24; the last-byte boundary at exactly the memory size; and the choice among faults when two or three coincide.

// File: rtl/oac_pkg.sv
package oac_pkg;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_SPEC = 2'd1,
    EXC_ADDR = 2'd2,
    EXC_PROT = 2'd3
  } excCode_t;

  // Fault flags raised by the datapath for the current request
  typedef struct packed {
    logic specFault;
    logic addrFault;
    logic protFault;
  } faultFlags_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     capture;
    logic     clear;
    excCode_t code;
    logic     suppress;
    logic     terminate;
  } ctlStrobe_t;

endpackage

// File: rtl/oac_datapath.sv
module oac_datapath
  import oac_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int GPR_W  = 32,
  parameter int RNUM_W = 4,
  parameter int DISP_W = 12,
  parameter int LEN_W  = 8,
  parameter int KEY_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [RNUM_W-1:0]   idxSel,
  input  logic [RNUM_W-1:0]   baseSel,
  input  logic [DISP_W-1:0]   disp,
  input  logic [GPR_W-1:0]    gprDataIdx,
  input  logic [GPR_W-1:0]    gprDataBase,
  input  logic [LEN_W-1:0]    lenM1,
  input  logic                isVarLen,
  input  logic                pairOp,
  input  logic [RNUM_W-1:0]   firstReg,
  input  logic [ADDR_W:0]     memSize,
  input  logic [KEY_W-1:0]    storKey,
  input  logic [KEY_W-1:0]    progKey,
  input  logic                protectEn,
  input  ctlStrobe_t          strobe,
  output faultFlags_t         faults,
  output logic                resValid,
  output logic [ADDR_W-1:0]   effAddr,
  output excCode_t            excCode,
  output logic                suppress,
  output logic                terminate
);

  localparam int WORD_BYTES_M1 = 3;
  localparam int DISP_PAD      = ADDR_W - DISP_W;
  localparam int LEN_PAD       = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] idxPart;
  logic [ADDR_W-1:0] basePart;
  logic [ADDR_W-1:0] dispPart;
  logic [ADDR_W-1:0] eaNext;
  logic [ADDR_W-1:0] spanPart;
  logic [ADDR_W-1:0] lastByte;
  logic              firstOut;
  logic              lastOut;
  logic              unusedBits;

  // Address components: a zero field contributes nothing
  always_comb begin
    idxPart  = (idxSel  == '0) ? '0 : gprDataIdx[ADDR_W-1:0];
    basePart = (baseSel == '0) ? '0 : gprDataBase[ADDR_W-1:0];
    dispPart = {{DISP_PAD{1'b0}}, disp};
    eaNext   = idxPart + basePart + dispPart;
  end

  // Span of the operand: full word or byte count from the length field
  always_comb begin
    spanPart = isVarLen ? {{LEN_PAD{1'b0}}, lenM1} : ADDR_W'(WORD_BYTES_M1);
    lastByte = eaNext + spanPart;
    firstOut = ({1'b0, eaNext}   >= memSize);
    lastOut  = ({1'b0, lastByte} >= memSize);
  end

  always_comb begin
    faults.specFault = (!isVarLen && (eaNext[1:0] != 2'b00)) || (pairOp && firstReg[0]);
    faults.addrFault = firstOut || lastOut;
    faults.protFault = protectEn && (progKey != '0) && (storKey != progKey);
  end

  assign unusedBits = ^{gprDataIdx[GPR_W-1:ADDR_W], gprDataBase[GPR_W-1:ADDR_W],
                        firstReg[RNUM_W-1:1]};

  // Result registers, loaded under control strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      effAddr   <= '0;
      excCode   <= EXC_NONE;
      suppress  <= 1'b0;
      terminate <= 1'b0;
    end else if (strobe.capture) begin
      resValid  <= 1'b1;
      effAddr   <= eaNext;
      excCode   <= strobe.code;
      suppress  <= strobe.suppress;
      terminate <= strobe.terminate;
    end else if (strobe.clear) begin
      resValid  <= 1'b0;
      excCode   <= EXC_NONE;
      suppress  <= 1'b0;
      terminate <= 1'b0;
    end
  end

  AST_ADDR_TERMINATES: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && excCode == EXC_ADDR) |-> (terminate && !suppress)); // R5

  AST_SPEC_SUPPRESSES: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && excCode == EXC_SPEC) |-> (suppress && !terminate)); // R4

  AST_CLEAN_NO_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && excCode == EXC_NONE) |-> (!suppress && !terminate)); // R8

endmodule

// File: rtl/oac_control.sv
module oac_control
  import oac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chkValid,
  input  logic        ssVarLen,
  input  faultFlags_t faults,
  output ctlStrobe_t  strobe
);

  excCode_t pickCode;

  // Fixed priority: specification, addressing, protection
  always_comb begin
    if (faults.specFault)      pickCode = EXC_SPEC;
    else if (faults.addrFault) pickCode = EXC_ADDR;
    else if (faults.protFault) pickCode = EXC_PROT;
    else                       pickCode = EXC_NONE;
  end

  always_comb begin
    strobe.capture   = chkValid;
    strobe.clear     = !chkValid;
    strobe.code      = pickCode;
    strobe.suppress  = 1'b0;
    strobe.terminate = 1'b0;
    unique case (pickCode)
      EXC_SPEC: strobe.suppress  = 1'b1;
      EXC_ADDR: strobe.terminate = 1'b1;
      EXC_PROT: begin
        strobe.suppress  = !ssVarLen;
        strobe.terminate = ssVarLen;
      end
      default: ;
    endcase
  end

  AST_STROBE_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.suppress && strobe.terminate)); // R6

  AST_PROT_SS_TERMINATES: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && ssVarLen && faults.protFault && !faults.specFault && !faults.addrFault)
      |-> (strobe.terminate && strobe.code == EXC_PROT)); // R6

endmodule

// File: rtl/opnd_access_check.sv
module opnd_access_check
  import oac_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int GPR_W  = 32,
  parameter int RNUM_W = 4,
  parameter int DISP_W = 12,
  parameter int LEN_W  = 8,
  parameter int KEY_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chkValid,
  input  logic [RNUM_W-1:0] idxSel,
  input  logic [RNUM_W-1:0] baseSel,
  input  logic [DISP_W-1:0] disp,
  output logic [RNUM_W-1:0] gprAddrIdx,
  input  logic [GPR_W-1:0]  gprDataIdx,
  output logic [RNUM_W-1:0] gprAddrBase,
  input  logic [GPR_W-1:0]  gprDataBase,
  input  logic [LEN_W-1:0]  lenM1,
  input  logic              isVarLen,
  input  logic              pairOp,
  input  logic [RNUM_W-1:0] firstReg,
  input  logic [ADDR_W:0]   memSize,
  input  logic [KEY_W-1:0]  storKey,
  input  logic [KEY_W-1:0]  progKey,
  input  logic              protectEn,
  input  logic              ssVarLen,
  output logic              resValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic [1:0]        excCode,
  output logic              suppress,
  output logic              terminate
);

  faultFlags_t faults;
  ctlStrobe_t  strobe;
  excCode_t    codeReg;

  assign gprAddrIdx  = idxSel;
  assign gprAddrBase = baseSel;
  assign excCode     = codeReg;

  oac_datapath #(
    .ADDR_W(ADDR_W), .GPR_W(GPR_W), .RNUM_W(RNUM_W),
    .DISP_W(DISP_W), .LEN_W(LEN_W), .KEY_W(KEY_W)
  ) uDatapath (
    .clk(clk), .rstN(rstN),
    .idxSel(idxSel), .baseSel(baseSel), .disp(disp),
    .gprDataIdx(gprDataIdx), .gprDataBase(gprDataBase),
    .lenM1(lenM1), .isVarLen(isVarLen), .pairOp(pairOp), .firstReg(firstReg),
    .memSize(memSize), .storKey(storKey), .progKey(progKey), .protectEn(protectEn),
    .strobe(strobe), .faults(faults),
    .resValid(resValid), .effAddr(effAddr), .excCode(codeReg),
    .suppress(suppress), .terminate(terminate)
  );

  oac_control uControl (
    .clk(clk), .rstN(rstN),
    .chkValid(chkValid), .ssVarLen(ssVarLen),
    .faults(faults), .strobe(strobe)
  );

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |=> resValid); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (excCode == 2'd0 && !suppress && !terminate)); // R3

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    !(suppress && terminate)); // R6

  AST_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && idxSel == '0 && baseSel == '0)
      |=> (effAddr == ADDR_W'($past(disp)))); // R2

  AST_ODD_PAIR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && pairOp && firstReg[0]) |=> (excCode == 2'd1)); // R7

  AST_PROT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && (!protectEn || progKey == '0)) |=> (excCode != 2'd3)); // R10

endmodule

// File: tb/sim_opnd_access_check.sv
`timescale 1ns/1ps
module sim_opnd_access_check;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chkValid = 1'b0;
  logic [3:0]  idxSel = '0, baseSel = '0, firstReg = '0;
  logic [11:0] disp = '0;
  logic [3:0]  gprAddrIdx, gprAddrBase;
  logic [31:0] gprDataIdx, gprDataBase;
  logic [7:0]  lenM1 = '0;
  logic        isVarLen = 1'b0, pairOp = 1'b0, protectEn = 1'b0, ssVarLen = 1'b0;
  logic [24:0] memSize = 25'h100_0000;
  logic [3:0]  storKey = '0, progKey = '0;
  logic        resValid, suppress, terminate;
  logic [23:0] effAddr;
  logic [1:0]  excCode;

  logic [31:0] gpr [16];
  assign gprDataIdx  = gpr[gprAddrIdx];
  assign gprDataBase = gpr[gprAddrBase];

  always #2.5 clk = ~clk;

  opnd_access_check u0 (
    .clk(clk), .rstN(rstN), .chkValid(chkValid),
    .idxSel(idxSel), .baseSel(baseSel), .disp(disp),
    .gprAddrIdx(gprAddrIdx), .gprDataIdx(gprDataIdx),
    .gprAddrBase(gprAddrBase), .gprDataBase(gprDataBase),
    .lenM1(lenM1), .isVarLen(isVarLen), .pairOp(pairOp), .firstReg(firstReg),
    .memSize(memSize), .storKey(storKey), .progKey(progKey),
    .protectEn(protectEn), .ssVarLen(ssVarLen),
    .resValid(resValid), .effAddr(effAddr), .excCode(excCode),
    .suppress(suppress), .terminate(terminate)
  );

  int    checks = 0;
  int    errors = 0;
  string curTag = "R9";
  bit    cmpOn  = 1'b0;

  // Expected state from the behavioural model
  int    expValid = 0, expCode = 0, expSup = 0, expTerm = 0;
  longint expAddr = 0;

  task automatic chk(string tag, string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  // Reference model evaluated at each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expValid = 0; expCode = 0; expSup = 0; expTerm = 0; expAddr = 0;
    end else if (chkValid) begin
      longint ix, bs, ea, last;
      bit specF, adrF, protF;
      ix   = (idxSel  == 0) ? 0 : longint'(gpr[idxSel]  % 32'h100_0000);
      bs   = (baseSel == 0) ? 0 : longint'(gpr[baseSel] % 32'h100_0000);
      ea   = (ix + bs + longint'(disp)) % 64'h100_0000;
      last = (ea + (isVarLen ? longint'(lenM1) : 3)) % 64'h100_0000;
      specF = (!isVarLen && (ea % 4) != 0) || (pairOp && (firstReg % 2) == 1);
      adrF  = (ea >= longint'(memSize)) || (last >= longint'(memSize));
      protF = protectEn && progKey != 0 && storKey != progKey;
      expCode = specF ? 1 : adrF ? 2 : protF ? 3 : 0;
      expSup  = (expCode == 1 || (expCode == 3 && !ssVarLen)) ? 1 : 0;
      expTerm = (expCode == 2 || (expCode == 3 && ssVarLen)) ? 1 : 0;
      expValid = 1;
      expAddr  = ea;
    end else begin
      expValid = 0; expCode = 0; expSup = 0; expTerm = 0;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (cmpOn) begin
      string t;
      t = (curTag == "auto") ?
          ((expCode == 1) ? "R4" : (expCode == 2) ? "R5" : (expCode == 3) ? "R6" : "R8") : curTag;
      chk("R3", "resValid", longint'(resValid), longint'(expValid));
      chk(t, "excCode", longint'(excCode), longint'(expCode));
      chk(t, "suppress", longint'(suppress), longint'(expSup));
      chk(t, "terminate", longint'(terminate), longint'(expTerm));
      if (expValid != 0) chk((curTag == "auto") ? "R1" : curTag, "effAddr",
                             longint'(effAddr), expAddr);
    end
  end

  task automatic issue(input logic [3:0] x, input logic [3:0] b, input logic [11:0] d,
                       input logic [7:0] len, input logic vl, input logic pr,
                       input logic [3:0] r1, input logic [24:0] mem,
                       input logic [3:0] sk, input logic [3:0] pk,
                       input logic pe, input logic ss);
    idxSel = x; baseSel = b; disp = d; lenM1 = len; isVarLen = vl; pairOp = pr;
    firstReg = r1; memSize = mem; storKey = sk; progKey = pk; protectEn = pe;
    ssVarLen = ss; chkValid = 1'b1;
    @(negedge clk);
    chkValid = 1'b0;
    @(negedge clk);
  endtask

  localparam logic [24:0] FULL = 25'h100_0000;

  initial begin
    for (int i = 0; i < 16; i++) gpr[i] = 32'h0001_0000 * i + 32'h40 * i;
    gpr[0]  = 32'hDEAD_BEEF;
    gpr[14] = 32'hAB00_0020;
    gpr[15] = 32'h00FF_FFF0;
    repeat (3) @(negedge clk);
    chk("R9", "reset resValid", longint'(resValid), 0);
    chk("R9", "reset excCode", longint'(excCode), 0);
    chk("R9", "reset effAddr", longint'(effAddr), 0);
    chk("R9", "reset action", longint'({suppress, terminate}), 0);
    rstN = 1'b1;
    cmpOn = 1'b1;
    @(negedge clk);

    curTag = "R1"; issue(3, 5, 12'h123, 0, 0, 0, 0, FULL, 0, 0, 0, 0);
    curTag = "R1"; issue(15, 14, 12'h010, 0, 0, 0, 0, FULL, 0, 0, 0, 0); // wraps past 2^24
    curTag = "R2"; issue(0, 0, 12'hABC, 4, 1, 0, 0, FULL, 0, 0, 0, 0);
    curTag = "R2"; issue(0, 4, 12'h008, 0, 0, 0, 0, FULL, 0, 0, 0, 0);
    curTag = "R4"; issue(0, 0, 12'h102, 0, 0, 0, 0, FULL, 0, 0, 0, 0);
    curTag = "R4"; issue(0, 0, 12'h100, 0, 0, 1, 3, FULL, 0, 0, 0, 0);
    curTag = "R5"; issue(0, 2, 12'h000, 0, 0, 0, 0, 25'h0002_0000, 0, 0, 0, 0);
    curTag = "R5"; issue(0, 0, 12'h0F0, 8'h10, 1, 0, 0, 25'h0000_0100, 0, 0, 0, 0);
    curTag = "R5"; issue(0, 0, 12'h0F0, 8'h0F, 1, 0, 0, 25'h0000_0100, 0, 0, 0, 0);
    curTag = "R5"; issue(0, 0, 12'h0FC, 0, 0, 0, 0, 25'h0000_0100, 0, 0, 0, 0);
    curTag = "R6"; issue(0, 0, 12'h200, 0, 0, 0, 0, FULL, 5, 6, 1, 0);
    curTag = "R6"; issue(0, 0, 12'h200, 3, 1, 0, 0, FULL, 5, 6, 1, 1);
    curTag = "R8"; issue(0, 0, 12'h200, 0, 0, 0, 0, FULL, 6, 6, 1, 0);
    curTag = "R10"; issue(0, 0, 12'h200, 0, 0, 0, 0, FULL, 5, 6, 0, 0);
    curTag = "R10"; issue(0, 0, 12'h200, 0, 0, 0, 0, FULL, 5, 0, 1, 1);
    curTag = "R7"; issue(0, 0, 12'hF01, 0, 0, 1, 1, 25'h0000_0100, 5, 6, 1, 0);
    curTag = "R7"; issue(0, 0, 12'hF00, 0, 0, 0, 0, 25'h0000_0100, 5, 6, 1, 1);

    // Back-to-back requests
    curTag = "R3";
    idxSel = 1; baseSel = 2; disp = 12'h004; isVarLen = 0; pairOp = 0;
    memSize = FULL; protectEn = 0; chkValid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      disp = disp + 12'h1;
    end
    chkValid = 1'b0;
    repeat (2) @(negedge clk);

    curTag = "auto";
    for (int n = 0; n < 600; n++) begin
      idxSel   = 4'($urandom_range(0, 15));
      baseSel  = 4'($urandom_range(0, 15));
      disp     = 12'($urandom);
      lenM1    = 8'($urandom);
      isVarLen = 1'($urandom);
      pairOp   = 1'($urandom_range(0, 3) == 0);
      firstReg = 4'($urandom);
      memSize  = ($urandom_range(0, 1) == 1) ? FULL : 25'($urandom_range(0, 32'h00C0_0000));
      storKey  = 4'($urandom_range(0, 3));
      progKey  = 4'($urandom_range(0, 3));
      protectEn = 1'($urandom);
      ssVarLen  = 1'($urandom);
      chkValid  = 1'($urandom_range(0, 3) != 0);
      @(negedge clk);
    end
    chkValid = 1'b0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int wdCount = 0;
  always @(posedge clk) begin
    wdCount++;
    if (wdCount > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got %0d exp below 50000", wdCount);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule